// File: doc/BRIEF.md
# GPIO Port Interrupt Detector

This block is one 8-pin general-purpose I/O port with per-pin interrupt detection. Each pin has an output value bit and an output-enable bit. Each pin's input is brought into the clock domain by a two-flop synchroniser. It can optionally be passed through a debounce filter. It is then judged against a per-pin trigger mode, which selects edge or level and picks the polarity.

Edge events are held in a per-pin latch until software clears them with a write-one-to-clear register. Level-triggered pins are never latched: their raw condition simply follows the qualified input. A per-pin enable masks the raw conditions into a pending vector. The OR of the pending vector drives one registered interrupt line.

Software reaches every control through a byte-wide register bus. Writes take effect at the clock edge on which `bus_wr` is high. Reads are combinational from `bus_addr`. The bus has no back-pressure: every access completes in the cycle it is presented. Dual-edge detection is left to software, which flips the polarity bit after each event.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset the output, direction, mode, polarity, enable and debounce registers are 0, `pin_oe` is 0 and `irq` is 0. With all pins low, the raw register reads 0xFF, because every pin then sits in active-low level mode.
- R2: The register map is: 0x0 output value, 0x1 direction (1 = drive), 0x2 mode (1 = edge, 0 = level), 0x3 polarity (1 = high/rising, 0 = low/falling), 0x4 clear, 0x5 enable, 0x6 pending (read-only), 0x7 raw (read-only), 0x8 debounce enable. `pin_out` equals the output-value register and `pin_oe` equals the direction register. A read of 0x0 returns the output-value bit for driven pins and the synchronised input for the other pins.
- R3: A pin in edge mode latches a raw bit on a rising synchronised input when its polarity bit is 1, and on a falling one when its polarity bit is 0. The raw bit is visible three clock edges after the pin changes.
- R4: A pin in level mode has a raw bit equal to its qualified input (polarity 1) or its inverse (polarity 0). Clear writes to such a pin have no effect on its raw bit.
- R5: Writing 1 to a bit of the clear register (0x4) clears that pin's edge latch. Writing 0 bits leaves the other latches alone. The clear register reads 0.
- R6: When an edge event and a clear for the same pin fall on the same clock edge, the latch ends up set.
- R7: The pending register equals raw AND enable. `irq` is the OR of pending, registered: it rises one clock edge after pending becomes non-zero.
- R8: A write to mode or polarity that changes a pin's bit clears that pin's edge latch. A write that leaves the bit unchanged keeps the latch.
- R9: With its debounce bit set, a pin's qualified input follows the synchronised input only after the new value has been seen on 4 consecutive `tick` samples. A shorter excursion is discarded and restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Debounce sample enable |
| pin_in | input | 8 | Raw pin inputs |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data |
| irq | output | 1 | Combined interrupt request |

## Verification
Two things can land on an edge latch at the same clock edge: a fresh input edge and a software clear. The bench provokes this by changing a pin just after a clock edge. It then holds a clear write to that pin across the third rising edge that follows, which is the edge on which the detector sets the latch. The outcome is judged by reading the raw register afterwards: the latch must be set. A separate clear issued in a quiet cycle must empty it.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_DATA = 4'h0,
    RA_DIR  = 4'h1,
    RA_MODE = 4'h2,
    RA_POL  = 4'h3,
    RA_CLR  = 4'h4,
    RA_EN   = 4'h5,
    RA_PEND = 4'h6,
    RA_RAW  = 4'h7,
    RA_DEB  = 4'h8
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int W    = 8,
  parameter int HOLD = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] d,
  output logic [W-1:0] filt
);
  localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt     <= '0;
        filt[i] <= 1'b0;
      end else if (tick) begin
        if (d[i] != filt[i]) begin
          if (cnt == LAST) begin
            filt[i] <= d[i];
            cnt     <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else begin
          cnt <= '0;
        end
      end
    end

    // R9: the filtered value only moves on a sample tick
    a_r9_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(filt[i]));
  end
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] qual,
  input  logic [W-1:0] mode,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] clr,
  input  logic [W-1:0] cfg_chg,
  output logic [W-1:0] raw
);
  logic [W-1:0] prev;
  logic [W-1:0] lat;
  logic [W-1:0] rise;
  logic [W-1:0] fall;
  logic [W-1:0] ev;
  logic [W-1:0] lvl;

  always_comb begin
    rise = qual & ~prev;
    fall = ~qual & prev;
    ev   = mode & ((pol & rise) | (~pol & fall));
    lvl  = (pol & qual) | (~pol & ~qual);
    raw  = (mode & lat) | (~mode & lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= '0;
      lat  <= '0;
    end else begin
      prev <= qual;
      lat  <= ~cfg_chg & ((lat & ~(clr & mode)) | ev);
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_chk
    // R5: a clear with no competing event empties the latch
    a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && mode[i] && !ev[i] && !cfg_chg[i]) |=> !lat[i]);
    // R6: a new event beats a clear on the same edge
    a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (ev[i] && !cfg_chg[i]) |=> lat[i]);
    // R8: a changed trigger setting drops the latch
    a_r8_cfg_drops: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_chg[i] |=> !lat[i]);
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int N_PINS   = 8,
  parameter int DEB_HOLD = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_oe,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_PINS-1:0] bus_wdata,
  output logic [N_PINS-1:0] bus_rdata,
  output logic              irq
);
  logic [N_PINS-1:0] data_q, dir_q, mode_q, pol_q, en_q, deb_q;
  logic [N_PINS-1:0] sync_in, filt_in, qual;
  logic [N_PINS-1:0] raw, pend, clr, cfg_chg;
  logic              wr_mode, wr_pol;

  gpio_sync #(.W(N_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_in)
  );

  gpio_debounce #(.W(N_PINS), .HOLD(DEB_HOLD)) u_deb (
    .clk(clk), .rst_n(rst_n), .tick(tick), .d(sync_in), .filt(filt_in)
  );

  always_comb begin
    qual    = (deb_q & filt_in) | (~deb_q & sync_in);
    wr_mode = bus_wr && (bus_addr == RA_MODE);
    wr_pol  = bus_wr && (bus_addr == RA_POL);
    cfg_chg = ({N_PINS{wr_mode}} & (bus_wdata ^ mode_q)) |
              ({N_PINS{wr_pol}}  & (bus_wdata ^ pol_q));
    clr     = (bus_wr && (bus_addr == RA_CLR)) ? bus_wdata : '0;
    pend    = raw & en_q;
  end

  gpio_detect #(.W(N_PINS)) u_det (
    .clk(clk), .rst_n(rst_n), .qual(qual), .mode(mode_q), .pol(pol_q),
    .clr(clr), .cfg_chg(cfg_chg), .raw(raw)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      mode_q <= '0;
      pol_q  <= '0;
      en_q   <= '0;
      deb_q  <= '0;
      irq    <= 1'b0;
    end else begin
      irq <= |pend;
      if (bus_wr) begin
        case (bus_addr)
          RA_DATA: data_q <= bus_wdata;
          RA_DIR:  dir_q  <= bus_wdata;
          RA_MODE: mode_q <= bus_wdata;
          RA_POL:  pol_q  <= bus_wdata;
          RA_EN:   en_q   <= bus_wdata;
          RA_DEB:  deb_q  <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      RA_DATA: bus_rdata = (dir_q & data_q) | (~dir_q & sync_in);
      RA_DIR:  bus_rdata = dir_q;
      RA_MODE: bus_rdata = mode_q;
      RA_POL:  bus_rdata = pol_q;
      RA_EN:   bus_rdata = en_q;
      RA_PEND: bus_rdata = pend;
      RA_RAW:  bus_rdata = raw;
      RA_DEB:  bus_rdata = deb_q;
      default: bus_rdata = '0;
    endcase
  end

  assign pin_out = data_q;
  assign pin_oe  = dir_q;

  // R7: the interrupt line is the registered OR of the pending vector
  a_r7_irq_registered: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|pend)));
  // R7: nothing is pending on a pin whose enable is clear
  a_r7_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~en_q) == '0);
endmodule

// File: tb/tb_gpio_irq_port.sv
module tb_gpio_irq_port;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out, pin_oe, bus_rdata;
  logic       bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       irq;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  gpio_irq_port dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=finish", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string rq, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", rq, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic setup_edges();
    wr(4'h5, 8'h00);
    wr(4'h8, 8'h00);
    @(negedge clk) pin_in = 8'h00;
    wait_cyc(4);
    wr(4'h2, 8'hFF);
    wr(4'h3, 8'hFF);
    wr(4'h4, 8'hFF);
    wait_cyc(2);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 pin_out", pin_out, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rd(4'h2, v); chk("R1 mode", v, 8'h00);
    rd(4'h5, v); chk("R1 enable", v, 8'h00);
    rd(4'h7, v); chk("R1 raw level-low", v, 8'hFF);
  endtask

  task automatic t_data_dir();
    logic [7:0] v;
    wr(4'h1, 8'h0F);
    wr(4'h0, 8'hA5);
    @(negedge clk) pin_in = 8'h30;
    wait_cyc(3);
    chk("R2 pin_out", pin_out, 8'hA5);
    chk("R2 pin_oe", pin_oe, 8'h0F);
    rd(4'h0, v); chk("R2 data read mix", v, 8'h35);
    @(negedge clk) pin_in = 8'h00;
    wr(4'h1, 8'h00);
    wait_cyc(3);
  endtask

  task automatic t_rise_fall();
    logic [7:0] v;
    setup_edges();
    @(negedge clk) pin_in = 8'h01;
    wait_cyc(4);
    rd(4'h7, v); chk("R3 rising latched", v, 8'h01);
    @(negedge clk) pin_in = 8'h00;
    wait_cyc(4);
    rd(4'h7, v); chk("R3 latch holds after fall", v, 8'h01);
    wr(4'h4, 8'h02);
    rd(4'h7, v); chk("R5 zero bit no effect", v, 8'h01);
    rd(4'h4, v); chk("R5 clear reads zero", v, 8'h00);
    wr(4'h4, 8'h01);
    rd(4'h7, v); chk("R5 clear empties", v, 8'h00);
    wr(4'h3, 8'hFE);
    @(negedge clk) pin_in = 8'h01;
    wait_cyc(4);
    rd(4'h7, v); chk("R3 falling ignores rise", v, 8'h00);
    @(negedge clk) pin_in = 8'h00;
    wait_cyc(4);
    rd(4'h7, v); chk("R3 falling latched", v, 8'h01);
  endtask

  task automatic t_level();
    logic [7:0] v;
    setup_edges();
    wr(4'h2, 8'h00);
    @(negedge clk) pin_in = 8'h10;
    wait_cyc(4);
    rd(4'h7, v); chk("R4 level high", v, 8'h10);
    wr(4'h4, 8'h10);
    rd(4'h7, v); chk("R4 clear ignored", v, 8'h10);
    @(negedge clk) pin_in = 8'h00;
    wait_cyc(4);
    rd(4'h7, v); chk("R4 follows level", v, 8'h00);
    wr(4'h3, 8'h00);
    rd(4'h7, v); chk("R4 active low", v, 8'hFF);
  endtask

  task automatic t_collision();
    logic [7:0] v;
    setup_edges();
    @(negedge clk) pin_in = 8'h04;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'h4; bus_wdata = 8'h04;
    @(posedge clk);
    @(negedge clk) bus_wr = 1'b0;
    rd(4'h7, v); chk("R6 event beats clear", v, 8'h04);
    wr(4'h4, 8'h04);
    rd(4'h7, v); chk("R5 later clear empties", v, 8'h00);
  endtask

  task automatic t_cfg_clear();
    logic [7:0] v;
    setup_edges();
    @(negedge clk) pin_in = 8'h03;
    wait_cyc(4);
    rd(4'h7, v); chk("R3 two latched", v, 8'h03);
    wr(4'h3, 8'hFE);
    rd(4'h7, v); chk("R8 polarity change clears", v, 8'h02);
    wr(4'h2, 8'hFF);
    rd(4'h7, v); chk("R8 same mode keeps", v, 8'h02);
  endtask

  task automatic t_mask_irq();
    logic [7:0] v;
    setup_edges();
    @(negedge clk) pin_in = 8'h08;
    wait_cyc(4);
    rd(4'h6, v); chk("R7 masked pending", v, 8'h00);
    chk("R7 masked irq", {7'd0, irq}, 8'h00);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'h5; bus_wdata = 8'h08;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 4'h6;
    #1 chk("R7 pending at once", bus_rdata, 8'h08);
    chk("R7 irq not yet", {7'd0, irq}, 8'h00);
    @(negedge clk);
    chk("R7 irq one edge later", {7'd0, irq}, 8'h01);
    wr(4'h4, 8'h08);
    @(negedge clk);
    chk("R7 irq drops", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_debounce();
    logic [7:0] v;
    setup_edges();
    wr(4'h8, 8'h01);
    @(negedge clk) pin_in = 8'h01;
    wait_cyc(3);
    ticks(3);
    wait_cyc(3);
    rd(4'h7, v); chk("R9 three ticks short", v, 8'h00);
    @(negedge clk) pin_in = 8'h00;
    wait_cyc(3);
    ticks(2);
    @(negedge clk) pin_in = 8'h01;
    wait_cyc(3);
    ticks(3);
    wait_cyc(3);
    rd(4'h7, v); chk("R9 count restarts", v, 8'h00);
    ticks(1);
    wait_cyc(3);
    rd(4'h7, v); chk("R9 four ticks pass", v, 8'h01);
  endtask

  initial begin
    wait_cyc(3);
    @(negedge clk) rst_n = 1'b1;
    wait_cyc(2);
    t_reset();
    t_data_dir();
    t_rise_fall();
    t_level();
    t_collision();
    t_cfg_clear();
    t_mask_irq();
    t_debounce();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule